// File: doc/BRIEF.md
# Serial-Command Multichannel DAC Register Controller

This block is the digital control core of a 32-channel, 14-bit digital-to-analogue converter. A host sends 32-bit command frames over a three-wire serial port made of an active-low select, a serial clock and a data line. The block receives each frame in its system clock domain, checks that the frame has exactly 32 bits, and then runs one register operation chosen by a 4-bit opcode. The operations are calibrated writes, uncalibrated bypass writes, deferred or immediate output updates, gain, offset and configuration writes, readbacks and a soft reset.

Each channel keeps an input register, an output (DAC) register, a gain register and an offset register. One configuration register is shared by all channels. Calibrated writes scale the data by the channel gain and add the channel offset, and the result is clipped to the code range. The output registers are driven out as one flat vector of 14-bit codes. They change on an immediate-update opcode, on a software load opcode, or on a falling edge of an active-low load pin. Readback data leaves on a serial output during the frame that follows the read command.

The receiver is a four-state machine. RX_IDLE goes to RX_SHIFT when the synchronised select falls. RX_SHIFT goes to RX_CHECK when select rises. RX_CHECK goes to RX_EXEC when the bit count is exactly 32, and otherwise back to RX_IDLE. RX_EXEC always returns to RX_IDLE after its single cycle.

Top module: `serdac_ctrl`

## Requirements
- R1: After the reset input, every output code is 0, every gain register holds 8192 (unity), every offset register holds 0, every input register holds 0, and the serial output presents all zeros.
- R2: The data line is sampled on falling edges of the serial clock while select is low, and the first bit is the frame MSB. A frame runs only if select rises after exactly 32 falling edges; frames of 31 or 33 bits change nothing. Field layout from MSB: opcode bits 31..28, address bits 27..22, data bits 21..8; bits 7..0 are unused.
- R3: Opcode 0000 (no operation) and the reserved opcodes 0101 and 0110 change no register, whatever the address and data.
- R4: Opcode 0001 stores the corrected data into the input registers of the selected channels and leaves the output codes unchanged.
- R5: The corrected value is (data × gain) >> 13 plus the offset read as a signed 14-bit number, clipped to the range 0..16383.
- R6: Opcode 0010 copies the input register into the output register for each selected channel and ignores the data field.
- R7: Opcode 0011 stores the corrected data into both the input register and the output register of each selected channel.
- R8: Opcode 0111 stores the raw data into the output registers of the selected channels and leaves their input registers unchanged.
- R9: Address 0..31 selects that one channel, address 32+k (k = 0..15) selects channels 2k and 2k+1, address 63 selects all channels, and every other address selects none.
- R10: A falling edge on the active-low load pin copies every input register into its output register; holding the pin low or releasing it has no further effect.
- R11: Opcode 1000 stores the raw data into the gain registers of the selected channels, and opcode 1001 stores it into their offset registers.
- R12: After a valid frame, the next frame shifts out 32 bits, MSB first, one bit per serial clock. The first 14 bits carry the read value and the remaining 18 bits are zero. The read values are: input register for 0100, gain for 1010, offset for 1011, configuration for 1101, output register for 1110. A channel read with an address of 32 or more returns 0, and every non-read opcode returns 0.
- R13: Opcode 1100 stores the data field into the configuration register, whatever the address.
- R14: Opcode 1111 restores every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| din | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Active-low load pin; its falling edge updates all outputs |
| dout | output | 1 | Serial readback data |
| dac_codes | output | 448 | Output codes, channel c at bits 14c+13..14c |

## Verification
Each opcode is sent with single-channel, pair, all-channel and unmapped addresses, so a wrong address decode changes some code on the flat output. Calibrated writes use unity, half and near-double gains with zero, positive and negative offsets, and the data is chosen so that both the lower and upper clip limits are reached. Deferred writes are followed by a software load and by a load-pin pulse, which separates the three update paths. Frames of 31 and 33 bits and the reserved opcodes check that nothing moves, and readback of every register kind goes through the serial output to expose stored but unseen state.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'h0,
        OP_WR_IN   = 4'h1,
        OP_SWLOAD  = 4'h2,
        OP_WR_UPD  = 4'h3,
        OP_RD_IN   = 4'h4,
        OP_RSV5    = 4'h5,
        OP_RSV6    = 4'h6,
        OP_BYPASS  = 4'h7,
        OP_WR_GAIN = 4'h8,
        OP_WR_OFS  = 4'h9,
        OP_RD_GAIN = 4'hA,
        OP_RD_OFS  = 4'hB,
        OP_WR_CFG  = 4'hC,
        OP_RD_CFG  = 4'hD,
        OP_RD_DAC  = 4'hE,
        OP_RESET   = 4'hF
    } op_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_CHECK,
        RX_EXEC
    } rx_state_e;

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] q_prev
);

    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= RST_VAL;
            end
            q_prev <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
            q_prev <= stg[STAGES-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/serdac_rx.sv
module serdac_rx
    import serdac_pkg::*;
#(
    parameter int FW = 32,
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          sclk_fall,
    input  logic          din_s,
    input  logic [DW-1:0] tx_word,
    output logic          exec,
    output logic [FW-1:0] frame,
    output logic          dout
);

    localparam int CNTW = $clog2(FW + 2);
    localparam logic [CNTW-1:0] CNT_MAX  = CNTW'(FW + 1);
    localparam logic [CNTW-1:0] CNT_GOOD = CNTW'(FW);

    rx_state_e       state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [FW-1:0]   sr_q;
    logic [FW-1:0]   tx_q;
    logic            shift_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!cs_n_s) state_d = RX_SHIFT;
            RX_SHIFT: if (cs_n_s)  state_d = RX_CHECK;
            RX_CHECK: state_d = (cnt_q == CNT_GOOD) ? RX_EXEC : RX_IDLE;
            RX_EXEC:  state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        exec     = (state_q == RX_EXEC);
        shift_en = (state_q == RX_SHIFT) && sclk_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
            tx_q  <= '0;
        end else begin
            if (state_q == RX_IDLE) begin
                cnt_q <= '0;
            end else if (shift_en) begin
                sr_q <= {sr_q[FW-2:0], din_s};
                if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (exec) begin
                tx_q <= {tx_word, {(FW-DW){1'b0}}};
            end else if (shift_en) begin
                tx_q <= {tx_q[FW-2:0], 1'b0};
            end
        end
    end

    assign frame = sr_q;
    assign dout  = tx_q[FW-1];

endmodule

// File: rtl/serdac_regs.sv
module serdac_regs
    import serdac_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 14,
    parameter int AW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  op_e               op,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     data,
    input  logic              ldac_fall,
    output logic [NCH*DW-1:0] dac_flat,
    output logic [NCH*DW-1:0] inp_flat,
    output logic [DW-1:0]     rd_word
);

    localparam int            CHW      = $clog2(NCH);
    localparam logic [DW-1:0] UNITY    = DW'(1) << (DW - 1);
    localparam logic [DW-1:0] CODE_MAX = '1;
    localparam logic [AW-1:0] ADDR_ALL = '1;

    logic [DW-1:0]  inp   [NCH];
    logic [DW-1:0]  dacr  [NCH];
    logic [DW-1:0]  gain  [NCH];
    logic [DW-1:0]  ofs   [NCH];
    logic [DW-1:0]  corr  [NCH];
    logic [DW-1:0]  cfg_q;
    logic [NCH-1:0] sel;

    function automatic logic [DW-1:0] calib(input logic [DW-1:0] d,
                                            input logic [DW-1:0] g,
                                            input logic [DW-1:0] o);
        logic [2*DW-1:0]      prod;
        logic signed [DW+2:0] sum;
        prod = {{DW{1'b0}}, d} * {{DW{1'b0}}, g};
        sum  = signed'({2'b00, prod[2*DW-1:DW-1]}) + signed'({{3{o[DW-1]}}, o});
        if (sum < 0) begin
            return '0;
        end else if (sum > signed'({3'b000, CODE_MAX})) begin
            return CODE_MAX;
        end else begin
            return sum[DW-1:0];
        end
    endfunction

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign sel[c] = (addr == AW'(c)) || (addr == AW'(NCH + c / 2)) || (addr == ADDR_ALL);
        assign corr[c] = calib(data, gain[c], ofs[c]);
        assign dac_flat[c*DW +: DW] = dacr[c];
        assign inp_flat[c*DW +: DW] = inp[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                inp[c]  <= '0;
                dacr[c] <= '0;
                gain[c] <= UNITY;
                ofs[c]  <= '0;
            end
            cfg_q <= '0;
        end else begin
            if (ldac_fall) begin
                for (int c = 0; c < NCH; c++) begin
                    dacr[c] <= inp[c];
                end
            end
            if (exec) begin
                unique case (op)
                    OP_WR_IN: begin
                        for (int c = 0; c < NCH; c++) if (sel[c]) inp[c] <= corr[c];
                    end
                    OP_SWLOAD: begin
                        for (int c = 0; c < NCH; c++) if (sel[c]) dacr[c] <= inp[c];
                    end
                    OP_WR_UPD: begin
                        for (int c = 0; c < NCH; c++) begin
                            if (sel[c]) begin
                                inp[c]  <= corr[c];
                                dacr[c] <= corr[c];
                            end
                        end
                    end
                    OP_BYPASS: begin
                        for (int c = 0; c < NCH; c++) if (sel[c]) dacr[c] <= data;
                    end
                    OP_WR_GAIN: begin
                        for (int c = 0; c < NCH; c++) if (sel[c]) gain[c] <= data;
                    end
                    OP_WR_OFS: begin
                        for (int c = 0; c < NCH; c++) if (sel[c]) ofs[c] <= data;
                    end
                    OP_WR_CFG: cfg_q <= data;
                    OP_RESET: begin
                        for (int c = 0; c < NCH; c++) begin
                            inp[c]  <= '0;
                            dacr[c] <= '0;
                            gain[c] <= UNITY;
                            ofs[c]  <= '0;
                        end
                        cfg_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Readback selection
    logic           single;
    logic [CHW-1:0] idx;

    always_comb begin
        single  = (addr < AW'(NCH));
        idx     = addr[CHW-1:0];
        rd_word = '0;
        unique case (op)
            OP_RD_IN:   if (single) rd_word = inp[idx];
            OP_RD_GAIN: if (single) rd_word = gain[idx];
            OP_RD_OFS:  if (single) rd_word = ofs[idx];
            OP_RD_DAC:  if (single) rd_word = dacr[idx];
            OP_RD_CFG:  rd_word = cfg_q;
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
    import serdac_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int DW     = 14,
    parameter int AW     = 6,
    parameter int FW     = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              ldac_n,
    output logic              dout,
    output logic [NCH*DW-1:0] dac_codes
);

    localparam int OPW     = 4;
    localparam int OP_MSB  = FW - 1;
    localparam int AD_MSB  = OP_MSB - OPW;
    localparam int DT_MSB  = AD_MSB - AW;

    logic [3:0]        pin_s, pin_p;
    logic              cs_n_s, din_s, sclk_fall, ldac_fall;
    logic              exec;
    logic [FW-1:0]     frame;
    logic [DW-1:0]     rd_word;
    logic [NCH*DW-1:0] inp_flat;
    logic [OPW-1:0]    op_bits;
    logic [AW-1:0]     f_addr;
    logic [DW-1:0]     f_data;

    serdac_sync #(
        .N       (4),
        .STAGES  (STAGES),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({ldac_n, din, sclk, cs_n}),
        .q      (pin_s),
        .q_prev (pin_p)
    );

    assign cs_n_s    = pin_s[0];
    assign sclk_fall = pin_p[1] & ~pin_s[1];
    assign din_s     = pin_s[2];
    assign ldac_fall = pin_p[3] & ~pin_s[3];

    serdac_rx #(
        .FW (FW),
        .DW (DW)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sclk_fall (sclk_fall),
        .din_s     (din_s),
        .tx_word   (rd_word),
        .exec      (exec),
        .frame     (frame),
        .dout      (dout)
    );

    assign op_bits = frame[OP_MSB -: OPW];
    assign f_addr  = frame[AD_MSB -: AW];
    assign f_data  = frame[DT_MSB -: DW];

    serdac_regs #(
        .NCH (NCH),
        .DW  (DW),
        .AW  (AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec      (exec),
        .op        (op_e'(op_bits)),
        .addr      (f_addr),
        .data      (f_data),
        .ldac_fall (ldac_fall),
        .dac_flat  (dac_codes),
        .inp_flat  (inp_flat),
        .rd_word   (rd_word)
    );

endmodule

// File: rtl/serdac_ctrl_chk.sv
module serdac_ctrl_chk #(
    parameter int NCH = 32,
    parameter int DW  = 14,
    parameter int AW  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec,
    input logic [3:0]        op,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     data,
    input logic              ldac_fall,
    input logic [NCH*DW-1:0] inp_flat,
    input logic [NCH*DW-1:0] dac_flat
);

    localparam int CHW = $clog2(NCH);

    logic [CHW-1:0] lat_addr;
    logic [DW-1:0]  picked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
        end else if (exec) begin
            lat_addr <= addr[CHW-1:0];
        end
    end

    assign picked = dac_flat[int'(lat_addr)*DW +: DW];

    // R2: a command runs for exactly one cycle
    p_exec_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> !exec);

    // R3: no-operation and reserved opcodes leave all state alone
    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ldac_fall && (op == 4'h0 || op == 4'h5 || op == 4'h6))
        |=> ($stable(dac_flat) && $stable(inp_flat)));

    // R4: deferred write does not touch outputs
    p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ldac_fall && op == 4'h1) |=> $stable(dac_flat));

    // R8: bypass puts raw data in the output and spares the input register
    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 4'h7 && addr < AW'(NCH))
        |=> (picked == $past(data) && $stable(inp_flat)));

    // R10: load-pin edge copies inputs to outputs
    p_ldac_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_fall && !exec) |=> (dac_flat == $past(inp_flat)));

    // R14: reset command clears the data registers
    p_reset_cmd_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 4'hF) |=> (dac_flat == '0 && inp_flat == '0));

endmodule

bind serdac_ctrl serdac_ctrl_chk #(
    .NCH (NCH),
    .DW  (DW),
    .AW  (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec      (exec),
    .op        (op_bits),
    .addr      (f_addr),
    .data      (f_data),
    .ldac_fall (ldac_fall),
    .inp_flat  (inp_flat),
    .dac_flat  (dac_codes)
);

// File: tb/sim_serdac_ctrl.sv
`timescale 1ns/1ps
module sim_serdac_ctrl;

    localparam int NCH = 32;
    localparam int DW  = 14;
    localparam int H   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic ldac_n = 1'b1;
    logic dout;
    logic [NCH*DW-1:0] dac_codes;

    always #10 clk = ~clk;

    serdac_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .ldac_n    (ldac_n),
        .dout      (dout),
        .dac_codes (dac_codes)
    );

    int tests = 0;
    int fails = 0;
    int minp [NCH];
    int mdac [NCH];
    int mgain[NCH];
    int mofs [NCH];
    int mcfg;
    logic [31:0] tx_exp;
    bit tx_known = 1'b0;
    bit busy = 1'b1;
    bit chk_en = 1'b0;
    string cur_req = "R1";

    function automatic bit is_sel(int c, int a);
        return (a == c) || (a >= NCH && a < NCH + NCH / 2 && (a - NCH) == c / 2) || (a == 63);
    endfunction

    function automatic int corrv(int d, int g, int o);
        int s;
        s = ((d * g) >>> 13) + ((o >= 8192) ? o - 16384 : o);
        if (s < 0) s = 0;
        if (s > 16383) s = 16383;
        return s;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            minp[c] = 0; mdac[c] = 0; mgain[c] = 8192; mofs[c] = 0;
        end
        mcfg = 0;
    endtask

    task automatic model_apply(int op, int a, int d);
        int rv;
        rv = 0;
        for (int c = 0; c < NCH; c++) begin
            if (is_sel(c, a)) begin
                case (op)
                    1: minp[c] = corrv(d, mgain[c], mofs[c]);
                    2: mdac[c] = minp[c];
                    3: begin minp[c] = corrv(d, mgain[c], mofs[c]); mdac[c] = minp[c]; end
                    7: mdac[c] = d;
                    8: mgain[c] = d;
                    9: mofs[c] = d;
                    default: ;
                endcase
            end
        end
        if (op == 12) mcfg = d;
        if (a < NCH) begin
            case (op)
                4:  rv = minp[a];
                10: rv = mgain[a];
                11: rv = mofs[a];
                14: rv = mdac[a];
                default: ;
            endcase
        end
        if (op == 13) rv = mcfg;
        if (op == 15) model_reset();
        tx_exp   = 32'(rv) << 18;
        tx_known = 1'b1;
    endtask

    // Compare output codes with the model on every clock outside update windows
    always @(negedge clk) begin
        if (chk_en && !busy) begin
            int bad;
            bad = -1;
            tests++;
            for (int c = 0; c < NCH; c++) begin
                if (bad < 0 && int'(dac_codes[c*DW +: DW]) != mdac[c]) bad = c;
            end
            if (bad >= 0) begin
                fails++;
                $display("FAIL %s ch%0d code actual=%0d expected=%0d", cur_req, bad,
                         dac_codes[bad*DW +: DW], mdac[bad]);
            end
        end
    end

    task automatic send_frame(input string req, input int op, input int a, input int d,
                              input int nbits);
        logic [31:0] w;
        logic [31:0] rd;
        bit chk_tx;
        cur_req = req;
        w  = (32'(op) << 28) | (32'(a) << 22) | (32'(d) << 8);
        rd = '0;
        chk_tx = tx_known;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            din  = (i < 32) ? w[31-i] : 1'b0;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            if (i < 32) rd[31-i] = dout;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        if (chk_tx && nbits >= 32) begin
            tests++;
            if (rd !== tx_exp) begin
                fails++;
                $display("FAIL R12 (before %s) dout actual=%h expected=%h", req, rd, tx_exp);
            end
        end
        busy = 1'b1;
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        if (nbits == 32) model_apply(op, a, d);
        else tx_known = 1'b0;
        busy = 1'b0;
    endtask

    task automatic pulse_ldac(input string req);
        cur_req = req;
        busy = 1'b1;
        ldac_n = 1'b0;
        repeat (10) @(negedge clk);
        for (int c = 0; c < NCH; c++) mdac[c] = minp[c];
        busy = 1'b0;
        repeat (6) @(negedge clk);
        ldac_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        model_reset();
        tx_exp = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tx_known = 1'b1;
        busy = 1'b0;
        chk_en = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset values, read back through the serial port
        send_frame("R1", 0, 0, 0, 32);
        send_frame("R1", 10, 5, 0, 32);
        send_frame("R1", 11, 5, 0, 32);
        send_frame("R1", 4, 5, 0, 32);

        // R8: bypass write to one channel, input untouched
        send_frame("R8", 7, 3, 1234, 32);
        send_frame("R8", 14, 3, 0, 32);
        send_frame("R8", 4, 3, 0, 32);

        // R11 and R7: gain/offset then immediate calibrated write
        send_frame("R11", 8, 4, 4096, 32);
        send_frame("R11", 9, 4, 100, 32);
        send_frame("R7", 3, 4, 1000, 32);
        send_frame("R11", 10, 4, 0, 32);
        send_frame("R11", 11, 4, 0, 32);

        // R5: clipping at both ends
        send_frame("R5", 9, 6, 16384 - 500, 32);
        send_frame("R5", 3, 6, 200, 32);
        send_frame("R5", 8, 7, 16383, 32);
        send_frame("R5", 9, 7, 8191, 32);
        send_frame("R5", 3, 7, 16383, 32);
        send_frame("R5", 14, 7, 0, 32);

        // R4 and R6: deferred write then software load
        send_frame("R4", 1, 10, 777, 32);
        send_frame("R4", 4, 10, 0, 32);
        send_frame("R6", 2, 10, 9999, 32);

        // R9: pair, all and unmapped addresses
        send_frame("R9", 1, 38, 50, 32);
        send_frame("R9", 2, 38, 0, 32);
        send_frame("R9", 7, 63, 9, 32);
        send_frame("R9", 7, 50, 4000, 32);
        send_frame("R9", 7, 48, 4001, 32);
        send_frame("R9", 7, 47, 4002, 32);

        // R10: load pin copies every input register
        send_frame("R10", 1, 63, 321, 32);
        pulse_ldac("R10");
        send_frame("R10", 14, 7, 0, 32);

        // R3: no-operation and reserved opcodes
        send_frame("R3", 0, 63, 5555, 32);
        send_frame("R3", 5, 63, 5555, 32);
        send_frame("R3", 6, 63, 5555, 32);
        send_frame("R3", 4, 0, 0, 32);

        // R2: frames of the wrong length are dropped
        send_frame("R2", 7, 63, 1111, 31);
        send_frame("R2", 7, 63, 1111, 33);
        send_frame("R2", 4, 12, 0, 32);
        send_frame("R2", 14, 12, 0, 32);

        // R13 and R12: configuration and non-single reads
        send_frame("R13", 12, 40, 12345, 32);
        send_frame("R13", 13, 63, 0, 32);
        send_frame("R12", 4, 63, 0, 32);
        send_frame("R12", 0, 0, 0, 32);

        // R14: reset command
        send_frame("R14", 15, 0, 0, 32);
        send_frame("R14", 10, 4, 0, 32);
        send_frame("R14", 13, 0, 0, 32);
        send_frame("R14", 0, 0, 0, 32);

        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule